// File: doc/BRIEF.md
# Two-Bit Variable-Rate Code-Group Assembler

This block sits in a receive path just under the coding sublayer. A clock-recovery stage in front of it hands over a recovered serial stream at zero, one or two bits per clock. The block packs those bits in arrival order into 5-bit code groups. It finds the group boundary by watching for the start-of-stream delimiter pair, and after that it emits one group with a single-cycle strobe every five received bits.

Each group is presented with its first-received bit in `group_o[4]` and its last-received bit in `group_o[0]`. The delimiter is the ten-bit sequence `1100010001`, sent first bit first. The delimiter groups themselves are consumed during alignment and are not emitted. The first strobed group is the one that follows the delimiter. A `resync_i` pulse, driven by the upstream idle-to-stream error detector, drops alignment and restarts the search.

Top module: `cga_assembler`

## Requirements
- R1: While `rst_ni` is low and right after reset, `group_stb_o` and `aligned_o` are 0 and `group_o` is 0.
- R2: A cycle with `rx_vld_i` = 0 and `resync_i` low consumes no bit: no strobe follows it and `aligned_o` does not change.
- R3: With `rx_vld_i` = 1, exactly one bit is taken, from `rx_bits_i[1]`; `rx_bits_i[0]` is ignored.
- R4: With `rx_vld_i` = 2, two bits are taken, `rx_bits_i[0]` first (older) and then `rx_bits_i[1]` (newer).
- R5: `rx_vld_i` = 3 behaves exactly like 2.
- R6: `aligned_o` rises in the cycle after the clock edge that takes the last bit of `1100010001` (received left to right), and no strobe is given in that cycle.
- R7: Once aligned, every fifth received bit completes a group. `group_o` shows the five bits with the first received in bit 4, and `group_stb_o` is high for one cycle.
- R8: A bit that arrives in the same transfer after the alignment point, or after a completed group, becomes the first bit of the next group.
- R9: `group_stb_o` is never high while `aligned_o` is low.
- R10: A cycle with `resync_i` high discards that cycle's bits, clears the bit history, and leaves `aligned_o` and `group_stb_o` low after the edge. A full delimiter must then be received again.
- R11: `group_stb_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_bits_i | input | 2 | Recovered bits, bit 1 newest |
| rx_vld_i | input | 2 | Count of valid bits: 0, 1, 2 (3 treated as 2) |
| resync_i | input | 1 | Drop alignment and restart the delimiter search |
| group_o | output | 5 | Assembled code group, first bit in bit 4 |
| group_stb_o | output | 1 | One-cycle strobe for a completed group |
| aligned_o | output | 1 | Group boundary fixed |

## Verification
The hardest case to reach from the ports is a boundary that falls between the two bits of a single transfer. The delimiter or a group ends on the older bit, and the newer bit has to be carried into the next group. The stimulus gets there with one leading pad bit and then two-bit transfers only. This places the last delimiter bit in the older slot and every second group end in the older slot too. A second scenario checks that bits arriving during a resync cycle are discarded. It feeds bits that would complete the delimiter only if the discarded bits had been kept.

// File: rtl/cga_pkg.sv
package cga_pkg;
  localparam int GRP_W  = 5;
  localparam int HIST_W = 2 * GRP_W;
  localparam int CNT_W  = $clog2(GRP_W);
  localparam int LANES  = 2;
  localparam logic [HIST_W-1:0] SYNC_PAT = 10'b11000_10001;

  typedef struct packed {
    logic [HIST_W-1:0] hist;
    logic [CNT_W-1:0]  cnt;
    logic              aligned;
  } cga_state_t;
endpackage

// File: rtl/cga_lane_order.sv
module cga_lane_order
  import cga_pkg::*;
(
  input  logic [1:0]       bits_i,
  input  logic [1:0]       vld_i,
  output logic [LANES-1:0] lane_bit_o,
  output logic [LANES-1:0] lane_en_o
);
  // lane 0 is processed first (older bit)
  always_comb begin
    if (vld_i[1]) begin
      lane_en_o  = 2'b11;
      lane_bit_o = {bits_i[1], bits_i[0]};
    end else if (vld_i[0]) begin
      lane_en_o  = 2'b01;
      lane_bit_o = {1'b0, bits_i[1]};
    end else begin
      lane_en_o  = 2'b00;
      lane_bit_o = 2'b00;
    end
  end
endmodule

// File: rtl/cga_bit_step.sv
module cga_bit_step
  import cga_pkg::*;
(
  input  cga_state_t       st_i,
  input  logic             en_i,
  input  logic             bit_i,
  output cga_state_t       st_o,
  output logic             emit_o,
  output logic [GRP_W-1:0] grp_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GRP_W - 1);

  logic [HIST_W-1:0] hist_nx;
  assign hist_nx = {st_i.hist[HIST_W-2:0], bit_i};

  always_comb begin
    st_o   = st_i;
    emit_o = 1'b0;
    grp_o  = hist_nx[GRP_W-1:0];
    if (en_i) begin
      st_o.hist = hist_nx;
      if (!st_i.aligned) begin
        if (hist_nx == SYNC_PAT) begin
          st_o.aligned = 1'b1;
          st_o.cnt     = '0;
        end
      end else if (st_i.cnt == LAST) begin
        st_o.cnt = '0;
        emit_o   = 1'b1;
      end else begin
        st_o.cnt = st_i.cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cga_assembler.sv
module cga_assembler
  import cga_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       rx_bits_i,
  input  logic [1:0]       rx_vld_i,
  input  logic             resync_i,
  output logic [GRP_W-1:0] group_o,
  output logic             group_stb_o,
  output logic             aligned_o
);
  cga_state_t             st_q;
  cga_state_t             chain [LANES+1];
  logic [LANES-1:0]       lane_bit, lane_en, emit;
  logic [GRP_W-1:0]       grp [LANES];
  logic                   emit_any;
  logic [GRP_W-1:0]       grp_sel;

  cga_lane_order u_order (
    .bits_i    (rx_bits_i),
    .vld_i     (rx_vld_i),
    .lane_bit_o(lane_bit),
    .lane_en_o (lane_en)
  );

  assign chain[0] = st_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cga_bit_step u_step (
      .st_i  (chain[g]),
      .en_i  (lane_en[g]),
      .bit_i (lane_bit[g]),
      .st_o  (chain[g+1]),
      .emit_o(emit[g]),
      .grp_o (grp[g])
    );
  end

  // at most one lane emits per cycle
  always_comb begin
    emit_any = 1'b0;
    grp_sel  = '0;
    for (int i = 0; i < LANES; i++) begin
      if (emit[i]) begin
        emit_any = 1'b1;
        grp_sel  = grp[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= '0;
      group_o     <= '0;
      group_stb_o <= 1'b0;
    end else if (resync_i) begin
      st_q        <= '0;
      group_stb_o <= 1'b0;
    end else begin
      st_q        <= chain[LANES];
      group_stb_o <= emit_any;
      if (emit_any) group_o <= grp_sel;
    end
  end

  assign aligned_o = st_q.aligned;

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_vld_i == 2'b00 && !resync_i) |=> (!group_stb_o && $stable(aligned_o)));
  a_r6_rise_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aligned_o) |-> !group_stb_o);
  a_r9_stb_needs_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    group_stb_o |-> aligned_o);
  a_r10_resync_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |=> (!aligned_o && !group_stb_o));
  a_r11_single_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    group_stb_o |=> !group_stb_o);
endmodule

// File: tb/cga_assembler_test.sv
module cga_assembler_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bits = '0;
  logic [1:0] vld = '0;
  logic       resync = 1'b0;
  logic [4:0] grp;
  logic       stb, aligned;

  int checks = 0, failures = 0, ncap = 0;
  logic [4:0] cap [16];
  logic prev_stb = 1'b0, dbl = 1'b0, done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cga_assembler uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_bits_i(bits), .rx_vld_i(vld),
    .resync_i(resync), .group_o(grp), .group_stb_o(stb), .aligned_o(aligned)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [1:0] v, input logic [1:0] d, input logic fl);
    vld = v; bits = d; resync = fl;
    @(posedge clk);
    #(CLK_P/4);
    if (stb) begin
      if (prev_stb) dbl = 1'b1;
      if (ncap < 16) cap[ncap] = grp;
      ncap++;
    end
    prev_stb = stb;
    vld = '0; resync = 1'b0;
  endtask

  // one bit per cycle, first bit = pat[n-1]; data[0] driven with junk (R3)
  task automatic send_ser(input logic [31:0] pat, input int n);
    for (int i = n - 1; i >= 0; i--) tick(2'b01, {pat[i], ~pat[i]}, 1'b0);
  endtask

  // two bits per cycle, older bit in data[0]
  task automatic send_par(input logic [31:0] pat, input int n, input logic [1:0] v);
    for (int i = n - 1; i > 0; i -= 2) tick(v, {pat[i-1], pat[i]}, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; vld = '0; resync = 1'b0;
    repeat (2) @(posedge clk);
    #(CLK_P/4);
    chk("R1 stb in reset", stb, 0);
    chk("R1 aligned in reset", aligned, 0);
    chk("R1 group in reset", grp, 0);
    rst_n = 1'b1;
    prev_stb = 1'b0; ncap = 0;
  endtask

  task automatic t_serial();
    do_reset();
    send_ser(7'b1111111, 7);
    send_ser(10'b1100010001 >> 1, 9);
    chk("R6 not aligned before last sync bit", aligned, 0);
    send_ser(1, 1);
    chk("R6 aligned after last sync bit", aligned, 1);
    chk("R6 no strobe on alignment", stb, 0);
    chk("R9 no groups before alignment", ncap, 0);
    send_ser(10'b10110_01011, 10);
    chk("R3 serial group count", ncap, 2);
    chk("R7 serial group 0", cap[0], 5'b10110);
    chk("R7 serial group 1", cap[1], 5'b01011);
  endtask

  task automatic t_pairs();
    logic [25:0] s;
    s = 26'b1_11000_10001_01101_10010_11100;
    do_reset();
    send_par(32'(s[25:16]), 10, 2'b10);
    chk("R4 not aligned before pair with sync end", aligned, 0);
    send_par(32'(s[15:14]), 2, 2'b10);
    chk("R8 aligned on older bit of pair", aligned, 1);
    chk("R8 no group yet", ncap, 0);
    send_par(32'(s[13:0]), 14, 2'b11);
    chk("R5 pair group count", ncap, 3);
    chk("R8 carried bit group 0", cap[0], 5'b01101);
    chk("R4 pair group 1", cap[1], 5'b10010);
    chk("R5 pair group 2", cap[2], 5'b11100);
    chk("R11 no back-to-back strobes", dbl, 0);
  endtask

  task automatic t_resync();
    tick(2'b10, 2'b11, 1'b1);
    chk("R10 aligned cleared", aligned, 0);
    chk("R10 no strobe", stb, 0);
    send_ser(8'b000_10001, 8);
    chk("R10 resync bits discarded", aligned, 0);
    send_ser(10'b1100010001, 10);
    chk("R10 realigned after full sync", aligned, 1);
    ncap = 0;
    tick(2'b10, 2'b00, 1'b0);
    tick(2'b00, 2'b11, 1'b0);
    chk("R2 idle no strobe", stb, 0);
    chk("R2 idle keeps alignment", aligned, 1);
    tick(2'b01, 2'b10, 1'b0);
    tick(2'b00, 2'b00, 1'b0);
    tick(2'b10, 2'b11, 1'b0);
    chk("R2 mixed group count", ncap, 1);
    chk("R7 mixed group value", cap[0], 5'b00111);
    chk("R11 no back-to-back strobes", dbl, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_serial();
    t_pairs();
    t_resync();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule